// File: doc/BRIEF.md
# Short-Pulse Event Synchronizer

This block moves a single-bit asynchronous event into a destination clock domain when the event may be much narrower than one destination clock period. The rising edge of the event line clocks a capture flag whose data is a constant one. The flag is set even when the event is over before any clock edge arrives. A chain of destination-clocked flops then resynchronizes the flag. The event appears at the output as a one-cycle pulse in the destination domain.

The last synchronizer stage feeds back to clear the capture flag asynchronously. That clear re-arms the block for the next event. Every event that arrives while the flag is already set is folded into the event that set it. The block has no counting, no data payload and no acknowledge back to the source side.

Top module: `short_pulse_sync`

## Requirements
- R1: While `rst` is high every flop, including the capture flag, is cleared and `evt_pulse` is 0. No pulse appears in the first cycle after `rst` falls.
- R2: A rising edge on `evt_in` sets the capture flag even when the high time of `evt_in` is shorter than one `clk` period and covers no `clk` rising edge. The event is reported at the output.
- R3: With the default `SYNC_STAGES` = 2, the event drives `evt_pulse` high in the cycle that follows the second `clk` rising edge after the `evt_in` rising edge. In general the count is `SYNC_STAGES` edges.
- R4: Each captured event produces `evt_pulse` high for exactly one `clk` cycle.
- R5: The capture flag is cleared once the output stage has seen the event. A new event that starts after the fourth `clk` rising edge following the previous event produces its own pulse.
- R6: Any further `evt_in` rising edge that arrives while the capture flag is still set is merged into the pending event. Only one pulse results.
- R7: `evt_in` edges that occur while `rst` is high leave no trace. No pulse appears after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| evt_in | input | 1 | Asynchronous event line; its rising edge is the event |
| clk | input | 1 | Destination domain clock |
| rst | input | 1 | Asynchronous active-high reset of all stages |
| evt_pulse | output | 1 | One-cycle pulse in the `clk` domain per captured event |

## Verification
Each event is launched at a chosen offset between two `clk` rising edges, with a high time well under one period. The output is then sampled at the falling edge after each of the next few rising edges. The pulse is due after rising edge number two and must be absent after edges one, three and four. Merged events and events during reset are observed over a longer window of falling-edge samples. Every sample must show exactly the number of pulses the requirement allows. Re-arm events are launched only after the fourth rising edge, which is when the clear of the capture flag is released.

// File: rtl/pulse_sync_pkg.sv
package pulse_sync_pkg;

    // Fewest destination flops that still give a resolution stage
    localparam int unsigned MIN_SYNC_STAGES = 2;

    // Cycles after the output pulse during which the capture clear stays active
    function automatic int unsigned blind_cycles(input int unsigned stages);
        return stages;
    endfunction

endpackage

// File: rtl/pulse_capture_cell.sv
// Edge-clocked capture flag: set by the event edge, cleared asynchronously.
module pulse_capture_cell (
    input  logic evt_in,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge evt_in or posedge clr) begin
        if (clr) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/pulse_sync_chain.sv
// Destination-side resynchronizer plus one-cycle pulse shaping.
module pulse_sync_chain
    import pulse_sync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_in,
    output logic last_stage,
    output logic evt_pulse
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   hist;
    } chain_t;

    chain_t st_d, st_q;

    initial begin
        if (SYNC_STAGES < MIN_SYNC_STAGES) begin
            $error("SYNC_STAGES must be at least %0d", MIN_SYNC_STAGES);
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = flag_in;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.hist    = st_q.sync[LAST];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_stage = st_q.sync[LAST];
    assign evt_pulse  = st_q.sync[LAST] & ~st_q.hist;

    // R4: a reported event lasts exactly one destination cycle
    assert_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |=> !evt_pulse);

    // R1: no pulse leaks out in the first cycle after reset release
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> !evt_pulse);

endmodule

// File: rtl/short_pulse_sync.sv
module short_pulse_sync
    import pulse_sync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic evt_in,
    input  logic clk,
    input  logic rst,
    output logic evt_pulse
);

    logic cap_flag;
    logic last_stage;
    logic rearm_clr;

    // Reset or a resynchronized flag clears the capture flop
    assign rearm_clr = rst | last_stage;

    pulse_capture_cell u_capture (
        .evt_in (evt_in),
        .clr    (rearm_clr),
        .flag   (cap_flag)
    );

    pulse_sync_chain #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .flag_in    (cap_flag),
        .last_stage (last_stage),
        .evt_pulse  (evt_pulse)
    );

    // R5: once the pulse is out, the capture flag has been re-armed
    assert_rearm_clear_R5: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |=> !cap_flag);

    // R2: a pulse is only reported for a flag that was actually captured
    assert_pulse_from_capture_R2: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |-> $past(cap_flag));

endmodule

// File: tb/test_short_pulse_sync.sv
`timescale 1ns/1ps
module test_short_pulse_sync;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt_in = 1'b0;
    logic evt_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    short_pulse_sync #(.SYNC_STAGES(2)) i_short_pulse_sync (
        .evt_in    (evt_in),
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Narrow event at a given offset after a clk rising edge
    task automatic fire(input real off, input real wid);
        @(posedge clk);
        #(off);
        evt_in = 1'b1;
        #(wid);
        evt_in = 1'b0;
    endtask

    // Sample the output at the falling edge after the next rising edge
    task automatic sample_next(output logic v);
        @(posedge clk);
        @(negedge clk);
        v = evt_pulse;
    endtask

    // R2, R3, R4: pulse present only after the second rising edge
    task automatic t_single(input real off, input real wid);
        logic v;
        fire(off, wid);
        for (int k = 1; k <= 4; k++) begin
            sample_next(v);
            if (k == 2) check(v === 1'b1, "R3 latency", int'(v), 1);
            else        check(v === 1'b0, "R4 single", int'(v), 0);
        end
    endtask

    task automatic t_reset;
        logic v;
        @(negedge clk);
        check(evt_pulse === 1'b0, "R1 in reset", int'(evt_pulse), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(evt_pulse === 1'b0, "R1 after release", int'(evt_pulse), 0);
        sample_next(v);
        check(v === 1'b0, "R1 idle", int'(v), 0);
    endtask

    // R6: second edge before the flag is cleared merges into one pulse
    task automatic t_merge;
        logic v;
        int cnt = 0;
        fire(2.0, 0.5);
        #(1.0);
        evt_in = 1'b1;
        #(0.5);
        evt_in = 1'b0;
        fire(3.0, 0.5);
        for (int k = 2; k <= 8; k++) begin
            sample_next(v);
            if (v === 1'b1) cnt++;
        end
        check(cnt == 1, "R6 merge", cnt, 1);
    endtask

    // R5: event after the fourth edge gets its own pulse
    task automatic t_rearm;
        logic v;
        int cnt = 0;
        fire(3.0, 0.7);
        for (int k = 1; k <= 4; k++) begin
            sample_next(v);
            if (v === 1'b1) cnt++;
        end
        fire(1.5, 0.7);
        for (int k = 1; k <= 4; k++) begin
            sample_next(v);
            if (v === 1'b1) cnt++;
            if (k == 2) check(v === 1'b1, "R5 rearm pulse", int'(v), 1);
        end
        check(cnt == 2, "R5 rearm count", cnt, 2);
    endtask

    // R7: events during reset leave nothing behind
    task automatic t_reset_ignore;
        logic v;
        int cnt = 0;
        @(negedge clk);
        rst = 1'b1;
        fire(2.5, 0.6);
        fire(6.0, 0.6);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            sample_next(v);
            if (v === 1'b1) cnt++;
        end
        check(cnt == 0, "R7 reset ignore", cnt, 0);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single(1.0, 0.6);
        t_single(3.7, 1.2);
        t_single(6.5, 0.4);
        t_single(7.2, 0.5);
        t_merge();
        t_rearm();
        t_reset_ignore();
        t_single(2.2, 0.3);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule